// File: doc/BRIEF.md
# Inverter Gate Protection Controller

This block sits between a motor-control PWM generator and the gate drivers of a three-phase bridge. It passes six active-high PWM commands to six gate-enable outputs: one upper and one lower switch per leg. Along the way it applies the protective rules of the bridge. The fault sources it watches are:

- a digitised short-circuit comparator flag taken from the shunt path;
- a pair of trip and reset flags for the lower control supply;
- a trip and reset pair for each upper bootstrap supply.

Faults are reported on an active-low output that models an open-drain line with a pull-up. Whenever that output is asserted, it stays asserted for at least a programmable number of clocks.

A short-circuit event must persist for a programmable number of consecutive clocks before it is accepted. Once accepted, it cuts all three lower gates in the cycle it is recognised and starts the fault pulse. Loss of the lower supply also cuts the lower gates and holds the fault line for the whole outage. Loss of an upper bootstrap supply cuts only that leg's upper gate, and it stays silent on the fault line. After any block, a gate comes back only when its command goes low and then rises again. A command that is still high when the block ends does not re-enable the gate.

Top module: `invGateProt`

## Requirements
- R1: With no block active and the channel armed, each gate output equals its PWM input as sampled at the previous clock edge (one register of latency).
- R2: The short-circuit flag trips only on the SC_FILT-th consecutive clock edge at which it is high. A run that is shorter than SC_FILT clocks has no effect on gates or on the fault line.
- R3: On the edge that recognises a short-circuit trip, all three lower gates go low whatever their inputs are. The upper gates are not affected.
- R4: After a short-circuit trip edge, faultN is low for exactly FO_WIDTH clocks. Every further clock with the flag high retriggers that count, so the line stays low while the short persists.
- R5: A lower-supply trip flag forces the lower gates low and drives faultN low. faultN stays low until the supply reset flag is seen and, in addition, for at least FO_WIDTH clocks counted from the last trip flag.
- R6: A trip flag on upper leg i forces gateHi[i] low until that leg's reset flag is seen. It does not affect other gates and does not drive faultN low.
- R7: Once a block has ended, a gate turns on only after its input has been sampled low and then sampled high. An input held high across the end of the block keeps the gate off.
- R8: During and after reset, all gates are low and every supply counts as under-voltage, so faultN is low until the lower-supply reset flag arrives. When a trip flag and a reset flag are high in the same clock, the trip wins.
- R9: faultN is high exactly when the lower supply is valid and no fault-width count is running. Upper-supply state never pulls it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwmHi | input | 3 | Upper-switch PWM commands, bit i = leg i, active high |
| pwmLo | input | 3 | Lower-switch PWM commands, bit i = leg i, active high |
| scFlag | input | 1 | Digitised short-circuit comparator output, high = over-current |
| lvTrip | input | 1 | Lower control supply fell below trip level |
| lvReset | input | 1 | Lower control supply rose above reset level |
| hvTrip | input | 3 | Upper bootstrap supply trip, one bit per leg |
| hvReset | input | 3 | Upper bootstrap supply reset, one bit per leg |
| gateHi | output | 3 | Upper gate enables, active high |
| gateLo | output | 3 | Lower gate enables, active high |
| faultN | output | 1 | Fault line, low = fault, high = no fault |

## Verification
The bench builds the block with SC_FILT = 3 and FO_WIDTH = 5. This puts both edges of the glitch filter and every expiry of the fault-width count within a handful of clocks. It sweeps short-circuit runs of one to six clocks, so it covers runs just below, at and above the threshold. It drives one-clock and long lower-supply outages, so it covers both the minimum-width case and the case where the outage itself sets the width. It also runs a long pseudo-random phase that mixes all fault sources with toggling commands. In every phase, an arithmetic model of the requirements predicts all seven outputs on every clock.

// File: rtl/invGateProt_pkg.sv
package invGateProt_pkg;
  localparam int LEGS = 3;

  // Control-to-datapath strobes: which gate groups are blocked this cycle
  typedef struct packed {
    logic            lowBlock;
    logic [LEGS-1:0] hiBlock;
  } gateStrobe_t;
endpackage

// File: rtl/invGateProtCell.sv
module invGateProtCell (
  input  logic clk,
  input  logic rstN,
  input  logic block,
  input  logic pwmIn,
  output logic gateOut
);
  logic inPrev;
  logic armed;
  logic rise;
  logic armNext;

  assign rise    = pwmIn & ~inPrev;
  assign armNext = ~block & (armed | rise);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPrev  <= 1'b0;
      armed   <= 1'b0;
      gateOut <= 1'b0;
    end else begin
      inPrev  <= pwmIn;
      armed   <= armNext;
      gateOut <= armNext & pwmIn;
    end
  end

  // R3 / R5 / R6: a blocked cycle leaves the gate off after the edge
  a_r3_block_kills_gate: assert property (@(posedge clk) disable iff (!rstN)
    block |=> !gateOut);

  // R7: a gate only comes on from an armed state or a fresh low-to-high input
  a_r7_fresh_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> ($past(pwmIn) && ($past(armed) || !$past(inPrev))));
endmodule

// File: rtl/invGateProtPath.sv
module invGateProtPath
  import invGateProt_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  gateStrobe_t     strb,
  input  logic [LEGS-1:0] pwmHi,
  input  logic [LEGS-1:0] pwmLo,
  output logic [LEGS-1:0] gateHi,
  output logic [LEGS-1:0] gateLo
);
  for (genvar leg = 0; leg < LEGS; leg++) begin : gLeg
    invGateProtCell uHi (
      .clk    (clk),
      .rstN   (rstN),
      .block  (strb.hiBlock[leg]),
      .pwmIn  (pwmHi[leg]),
      .gateOut(gateHi[leg])
    );
    invGateProtCell uLo (
      .clk    (clk),
      .rstN   (rstN),
      .block  (strb.lowBlock),
      .pwmIn  (pwmLo[leg]),
      .gateOut(gateLo[leg])
    );

    // R6: an upper block acts on its own leg only
    a_r6_upper_leg_off: assert property (@(posedge clk) disable iff (!rstN)
      strb.hiBlock[leg] |=> !gateHi[leg]);
  end

  // R3: a lower block clears every lower gate together
  a_r3_lower_all_off: assert property (@(posedge clk) disable iff (!rstN)
    strb.lowBlock |=> (gateLo == '0));
endmodule

// File: rtl/invGateProtCtrl.sv
module invGateProtCtrl
  import invGateProt_pkg::*;
#(
  parameter int SC_FILT  = 4,
  parameter int FO_WIDTH = 240000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            scFlag,
  input  logic            lvTrip,
  input  logic            lvReset,
  input  logic [LEGS-1:0] hvTrip,
  input  logic [LEGS-1:0] hvReset,
  output gateStrobe_t     strb,
  output logic            faultN
);
  localparam int SCW = $clog2(SC_FILT + 1);
  localparam int FOW = $clog2(FO_WIDTH + 1);
  localparam logic [SCW-1:0] SC_LAST = SCW'(SC_FILT - 1);
  localparam logic [FOW-1:0] FO_LOAD = FOW'(FO_WIDTH);

  logic [SCW-1:0]  scRun;
  logic            scTrip;
  logic [FOW-1:0]  foCnt;
  logic            foBusy;
  logic            lvUv;
  logic [LEGS-1:0] hvUv;

  assign scTrip = scFlag && (scRun == SC_LAST);
  assign foBusy = (foCnt != '0);

  // Glitch filter: count consecutive high samples, hold at the threshold
  always_ff @(posedge clk) begin
    if (!rstN)          scRun <= '0;
    else if (!scFlag)   scRun <= '0;
    else if (!scTrip)   scRun <= scRun + 1'b1;
  end

  // Fault-width timer, reloaded by every trip event
  always_ff @(posedge clk) begin
    if (!rstN)                 foCnt <= '0;
    else if (scTrip || lvTrip) foCnt <= FO_LOAD;
    else if (foBusy)           foCnt <= foCnt - 1'b1;
  end

  // Lower supply state: under-voltage from reset, trip beats reset flag
  always_ff @(posedge clk) begin
    if (!rstN)        lvUv <= 1'b1;
    else if (lvTrip)  lvUv <= 1'b1;
    else if (lvReset) lvUv <= 1'b0;
  end

  for (genvar leg = 0; leg < LEGS; leg++) begin : gHv
    always_ff @(posedge clk) begin
      if (!rstN)             hvUv[leg] <= 1'b1;
      else if (hvTrip[leg])  hvUv[leg] <= 1'b1;
      else if (hvReset[leg]) hvUv[leg] <= 1'b0;
    end
  end

  always_comb begin
    strb.lowBlock = lvUv | lvTrip | scTrip | foBusy;
    strb.hiBlock  = hvUv | hvTrip;
  end

  assign faultN = ~(lvUv | foBusy);

  // R2: a trip is only recognised with the flag present now and before
  a_r2_filter_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (scTrip && (SC_FILT > 1)) |-> $past(scFlag));

  // R4: the fault line is low right after a short-circuit trip
  a_r4_sc_fault_out: assert property (@(posedge clk) disable iff (!rstN)
    scTrip |=> !faultN);

  // R5: a lower-supply trip loads the full fault width
  a_r5_uv_full_width: assert property (@(posedge clk) disable iff (!rstN)
    lvTrip |=> (foCnt == FO_LOAD) && !faultN);

  // R8: reset flag alone clears the lower under-voltage state
  a_r8_uv_release: assert property (@(posedge clk) disable iff (!rstN)
    (lvReset && !lvTrip) |=> !lvUv);
endmodule

// File: rtl/invGateProt.sv
module invGateProt
  import invGateProt_pkg::*;
#(
  parameter int SC_FILT  = 4,
  parameter int FO_WIDTH = 240000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] pwmHi,
  input  logic [2:0] pwmLo,
  input  logic       scFlag,
  input  logic       lvTrip,
  input  logic       lvReset,
  input  logic [2:0] hvTrip,
  input  logic [2:0] hvReset,
  output logic [2:0] gateHi,
  output logic [2:0] gateLo,
  output logic       faultN
);
  gateStrobe_t strb;

  invGateProtCtrl #(
    .SC_FILT (SC_FILT),
    .FO_WIDTH(FO_WIDTH)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .scFlag (scFlag),
    .lvTrip (lvTrip),
    .lvReset(lvReset),
    .hvTrip (hvTrip),
    .hvReset(hvReset),
    .strb   (strb),
    .faultN (faultN)
  );

  invGateProtPath uPath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .pwmHi (pwmHi),
    .pwmLo (pwmLo),
    .gateHi(gateHi),
    .gateLo(gateLo)
  );

  // R9: upper-supply trips alone never pull the fault line low
  a_r9_upper_silent: assert property (@(posedge clk) disable iff (!rstN)
    (faultN && !scFlag && !lvTrip && (hvTrip != '0)) |=> faultN);
endmodule

// File: tb/invGateProt_test.sv
module invGateProt_test;
  localparam int SCF = 3;
  localparam int FOW = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] pwmHi = '0, pwmLo = '0;
  logic       scFlag = 1'b0, lvTrip = 1'b0, lvReset = 1'b0;
  logic [2:0] hvTrip = '0, hvReset = '0;
  logic [2:0] gateHi, gateLo;
  logic       faultN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int       scRunM = 0;
  int       foRemM = 0;
  bit       lvUvM = 1;
  bit [2:0] hvUvM = '1;
  bit [5:0] armM = '0, prevM = '0, gateM = '0;
  bit       faultM = 0;

  invGateProt #(.SC_FILT(SCF), .FO_WIDTH(FOW)) uut (
    .clk(clk), .rstN(rstN), .pwmHi(pwmHi), .pwmLo(pwmLo), .scFlag(scFlag),
    .lvTrip(lvTrip), .lvReset(lvReset), .hvTrip(hvTrip), .hvReset(hvReset),
    .gateHi(gateHi), .gateLo(gateLo), .faultN(faultN)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    bit trip, lowBlk, inb, blk, rise, a;
    trip   = scFlag && (scRunM + 1 >= SCF);
    lowBlk = lvUvM || (foRemM > 0) || trip || lvTrip;
    for (int c = 0; c < 6; c++) begin
      inb  = (c < 3) ? pwmHi[c] : pwmLo[c-3];
      blk  = (c < 3) ? (hvUvM[c] || hvTrip[c]) : lowBlk;
      rise = inb && !prevM[c];
      a    = !blk && (armM[c] || rise);
      armM[c]  = a;
      prevM[c] = inb;
      gateM[c] = a && inb;
    end
    scRunM = scFlag ? scRunM + 1 : 0;
    if (trip || lvTrip) foRemM = FOW;
    else if (foRemM > 0) foRemM--;
    if (lvTrip) lvUvM = 1; else if (lvReset) lvUvM = 0;
    for (int l = 0; l < 3; l++) begin
      if (hvTrip[l]) hvUvM[l] = 1; else if (hvReset[l]) hvUvM[l] = 0;
    end
    faultM = !(lvUvM || (foRemM > 0));
  endtask

  task automatic compareAll(input string tag);
    check(tag, "gateHi", int'(gateHi), int'(gateM[2:0]));
    check(tag, "gateLo", int'(gateLo), int'(gateM[5:3]));
    check(tag, "faultN", int'(faultN), int'(faultM));
  endtask

  // inputs are set at a negedge; one clock edge; compare at the next negedge
  task automatic step(input string tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic clearFlags();
    scFlag = 0; lvTrip = 0; lvReset = 0; hvTrip = '0; hvReset = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    pwmHi = '1; pwmLo = '1;
    repeat (3) @(negedge clk);
    check("R8", "gateHi in reset", int'(gateHi), 0);
    check("R8", "gateLo in reset", int'(gateLo), 0);
    check("R8", "faultN in reset", int'(faultN), 0);
    rstN = 1;
    for (int i = 0; i < 4; i++) step("R8");   // still under-voltage everywhere

    // R8: trip beats reset flag in the same clock
    lvTrip = 1; lvReset = 1; hvTrip = 3'b001; hvReset = 3'b111; step("R8");
    clearFlags();
    for (int i = 0; i < 7; i++) step("R8");

    // power up all supplies; inputs still high -> R7 no gate
    lvReset = 1; hvReset = '1; step("R7"); clearFlags();
    for (int i = 0; i < 8; i++) step("R7");
    pwmHi = '0; pwmLo = '0; step("R7");
    pwmHi = '1; pwmLo = '1; step("R7");
    check("R7", "gateHi after fresh edge", int'(gateHi), 7);

    // R1: follow patterns
    for (int p = 0; p < 64; p++) begin
      pwmHi = p[2:0]; pwmLo = p[5:3]; step("R1");
    end

    // R2/R3/R4: short-circuit run-length sweep
    for (int len = 1; len <= 6; len++) begin
      pwmHi = '1; pwmLo = '0; step("R7"); pwmLo = '1; step("R1");
      scFlag = 1;
      for (int k = 0; k < len; k++) step((len < SCF) ? "R2" : "R3");
      scFlag = 0;
      for (int k = 0; k < FOW + 3; k++) step("R4");
      check("R9", "faultN idle after sweep", int'(faultN), 1);
    end

    // R5: one-clock lower under-voltage, min width
    pwmLo = '0; step("R5"); pwmLo = '1; step("R5");
    lvTrip = 1; step("R5"); lvTrip = 0; lvReset = 1;
    for (int k = 0; k < FOW + 3; k++) step("R5");
    lvReset = 0;
    // R5: long outage
    lvTrip = 1; step("R5"); lvTrip = 0;
    for (int k = 0; k < 20; k++) step("R5");
    check("R5", "faultN during long outage", int'(faultN), 0);
    lvReset = 1; step("R5"); lvReset = 0;
    for (int k = 0; k < 4; k++) step("R5");
    pwmLo = '0; step("R7"); pwmLo = 3'b101; step("R7");

    // R6: upper leg trip, silent
    for (int l = 0; l < 3; l++) begin
      pwmHi = '0; step("R6"); pwmHi = '1; step("R6");
      hvTrip[l] = 1; step("R6"); hvTrip[l] = 0;
      for (int k = 0; k < 4; k++) step("R6");
      check("R6", "faultN stays high", int'(faultN), 1);
      hvReset[l] = 1; step("R6"); hvReset[l] = 0;
      step("R7"); pwmHi[l] = 0; step("R7"); pwmHi[l] = 1; step("R7");
    end

    // mixed pseudo-random sweep
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 3) == 0) pwmHi = pwmHi ^ 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) pwmLo = pwmLo ^ 3'($urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) scFlag = ~scFlag;
      lvTrip  = ($urandom_range(0, 199) == 0);
      lvReset = ($urandom_range(0, 19) == 0);
      for (int l = 0; l < 3; l++) begin
        hvTrip[l]  = ($urandom_range(0, 149) == 0);
        hvReset[l] = ($urandom_range(0, 19) == 0);
      end
      step("R1");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule